// File: doc/BRIEF.md
# Dual-Channel Level and Rate-of-Change Alarm

This block watches two user-selected 16-bit measurement streams and raises an alarm when one of them crosses a programmed boundary. Each of the two channels picks its input from a bank of sensor lanes. The input can be the raw or the filtered version of the lane, or a derived "status word is nonzero" value. A channel then compares the signed input against its threshold, using either greater-than or less-than. In level mode it compares the present value. In rate mode it compares the difference between the present value and the value a programmed number of samples earlier. Work happens only on a sample strobe from the producer of the data.

The two comparison results are registered as "active" bits. They also set two sticky flags, which stay set until a clear pulse. The OR of the active bits can drive one of two shared output lines at a programmable polarity. On each line, a data-ready pulse routed to that line takes precedence over the alarm. General-purpose output levels fill any line that neither of them claims. A single 16-bit control word holds the configuration: the source code, mode and polarity of each channel, the raw/filtered choice, and the indicator routing.

Top module: `dual_alarm_monitor`

## Requirements
- R1: Source code (channel 1 in control bits 11:8, channel 2 in bits 15:12) chooses the input. Codes 1..8 select lane code-1 of the sensor bus, where lane k is bits 16k+15:16k. Code 9 selects the value 1 when the status word is nonzero and 0 otherwise. Code 0 and codes 10..15 leave the channel permanently inactive.
- R2: Control bit 3 set takes lanes from the filtered bus, and clear takes them from the raw bus, for both channels.
- R3: Polarity bit 1 (channel 1 bit 4, channel 2 bit 5) makes a channel active when its signed compared value is strictly greater than the signed threshold. Equality is not active.
- R4: Polarity bit 0 makes a channel active when its signed compared value is strictly less than the signed threshold.
- R5: Mode bit set (channel 1 bit 6, channel 2 bit 7) compares the present input minus the input N strobes earlier, where N is the channel's 8-bit window value and 0 counts as 1. The difference is 17-bit signed and never wraps.
- R6: In rate mode the channel stays inactive until N samples have been captured since reset or since its source code last changed. A change of source code discards the captured history.
- R7: Active bits change only at a clock edge where sample_stb is high, and they hold between strobes. A strobe's result is visible after that edge.
- R8: Each flag is set at any strobe that finds its channel active. It stays set until a cycle with flag_clr high. Clear and a new activation at the same edge leave the flag set. Flags are 0 after reset.
- R9: With control bit 2 set, the line chosen by bit 0 (0 = line 0, 1 = line 1) carries the level of bit 1 while either channel is active, and the inverse level otherwise.
- R10: Per line, the priority is: data-ready level (when drdy_en and drdy_sel name the line), then the alarm indicator, then gpio_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | New sample present; evaluate and capture |
| raw_bus | input | 128 | Eight raw 16-bit sensor lanes |
| filt_bus | input | 128 | Eight filtered 16-bit sensor lanes |
| status_word | input | 16 | Status word tested for nonzero by source code 9 |
| ctrl_word | input | 16 | Packed channel and indicator configuration |
| thresh1 | input | 16 | Channel 1 signed threshold |
| thresh2 | input | 16 | Channel 2 signed threshold |
| window1 | input | 8 | Channel 1 rate window in samples |
| window2 | input | 8 | Channel 2 rate window in samples |
| flag_clr | input | 1 | Clear both sticky flags |
| drdy_en | input | 1 | Data-ready output enabled |
| drdy_sel | input | 1 | Line carrying data-ready |
| drdy_lvl | input | 1 | Current data-ready level |
| gpio_lvl | input | 2 | Fallback general-purpose level per line |
| alarm_active | output | 2 | Registered per-channel active result |
| alarm_flag | output | 2 | Sticky per-channel flags |
| line_out | output | 2 | Shared output lines |

## Verification
Active bits and flags are registered at the edge where the strobe is sampled, so they are due one clock after the stimulus. The line outputs follow those registers and the routing inputs through logic only. The bench drives every input on a falling edge and updates its model for the next rising edge. It checks at the following falling edge, so each comparison lands exactly one edge after its stimulus. Rate-mode checks count strobes, not cycles: the bench model keeps its own ring of past inputs and its own fill count, reset whenever a source code changes.

// File: rtl/alarm_mon_pkg.sv
`timescale 1ns/1ps
package alarm_mon_pkg;

  localparam int SMP_W = 16;

  typedef logic [3:0] src_sel_t;

  typedef struct packed {
    src_sel_t src;
    logic     dyn;
    logic     gt;
  } chan_cfg_t;

  // Pull one channel's fields from the packed control word.
  function automatic chan_cfg_t cfg_of(input logic [15:0] ctrl, input int ch);
    chan_cfg_t c;
    if (ch == 0) begin
      c.src = ctrl[11:8];
      c.dyn = ctrl[6];
      c.gt  = ctrl[4];
    end else begin
      c.src = ctrl[15:12];
      c.dyn = ctrl[7];
      c.gt  = ctrl[5];
    end
    return c;
  endfunction

  // Sign-extend one sample by one bit.
  function automatic logic [SMP_W:0] widen(input logic [SMP_W-1:0] v);
    return {v[SMP_W-1], v};
  endfunction

  // Difference of two samples with headroom so it cannot wrap.
  function automatic logic [SMP_W:0] step_diff(input logic [SMP_W-1:0] now_v,
                                               input logic [SMP_W-1:0] old_v);
    return widen(now_v) - widen(old_v);
  endfunction

  // Signed strict comparison in the requested direction.
  function automatic logic crosses(input logic [SMP_W:0] v,
                                   input logic [SMP_W:0] thr,
                                   input logic gt);
    if (gt) return $signed(v) > $signed(thr);
    else    return $signed(v) < $signed(thr);
  endfunction

endpackage

// File: rtl/alarm_src_mux.sv
`timescale 1ns/1ps
module alarm_src_mux
  import alarm_mon_pkg::*;
#(
  parameter int LANES = 8,
  localparam int BUS_W = LANES * SMP_W
) (
  input  logic [BUS_W-1:0] raw_bus,
  input  logic [BUS_W-1:0] filt_bus,
  input  logic [SMP_W-1:0] status_word,
  input  logic             use_filt,
  input  src_sel_t         sel,
  output logic [SMP_W-1:0] value,
  output logic             valid
);

  always_comb begin
    value = '0;
    valid = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (int'(sel) == l + 1) begin
        value = use_filt ? filt_bus[l*SMP_W +: SMP_W] : raw_bus[l*SMP_W +: SMP_W];
        valid = 1'b1;
      end
    end
    if (int'(sel) == LANES + 1) begin
      value = {{(SMP_W-1){1'b0}}, |status_word};
      valid = 1'b1;
    end
  end

endmodule

// File: rtl/alarm_history.sv
`timescale 1ns/1ps
module alarm_history
  import alarm_mon_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int LAG_W = $clog2(DEPTH),
  localparam int FILL_W = LAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             flush,
  input  logic [SMP_W-1:0] din,
  input  logic [LAG_W-1:0] lag,
  output logic [SMP_W-1:0] old_val,
  output logic             ready
);

  logic [SMP_W-1:0]  mem [DEPTH];
  logic [LAG_W-1:0]  wp_q;
  logic [LAG_W-1:0]  lag_eff;
  logic [LAG_W-1:0]  rd_idx;
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_eff;
  logic [FILL_W-1:0] fill_nxt;

  assign lag_eff  = (lag == '0) ? LAG_W'(1) : lag;
  assign rd_idx   = wp_q - lag_eff;
  assign old_val  = mem[rd_idx];
  assign fill_eff = flush ? '0 : fill_q;
  assign ready    = fill_eff >= FILL_W'(lag_eff);
  assign fill_nxt = (fill_eff == FILL_W'(DEPTH)) ? fill_eff : fill_eff + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else if (push) begin
      wp_q   <= wp_q + 1'b1;
      fill_q <= fill_nxt;
    end else begin
      fill_q <= fill_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/alarm_eval.sv
`timescale 1ns/1ps
module alarm_eval
  import alarm_mon_pkg::*;
(
  input  chan_cfg_t        cfg,
  input  logic [SMP_W-1:0] value,
  input  logic             valid,
  input  logic [SMP_W-1:0] old_val,
  input  logic             hist_ready,
  input  logic [SMP_W-1:0] thr,
  output logic             trip
);

  logic [SMP_W:0] level_w;
  logic [SMP_W:0] delta_w;
  logic [SMP_W:0] thr_w;
  logic           lvl_hit;
  logic           rate_hit;

  assign level_w  = widen(value);
  assign delta_w  = step_diff(value, old_val);
  assign thr_w    = widen(thr);
  assign lvl_hit  = crosses(level_w, thr_w, cfg.gt);
  assign rate_hit = hist_ready && crosses(delta_w, thr_w, cfg.gt);
  assign trip     = valid && (cfg.dyn ? rate_hit : lvl_hit);

endmodule

// File: rtl/alarm_pin_route.sv
`timescale 1ns/1ps
module alarm_pin_route #(
  parameter int LINES = 2,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             any_act,
  input  logic             ind_en,
  input  logic             ind_hi,
  input  logic [SEL_W-1:0] ind_sel,
  input  logic             drdy_en,
  input  logic [SEL_W-1:0] drdy_sel,
  input  logic             drdy_lvl,
  input  logic [LINES-1:0] gpio_lvl,
  output logic [LINES-1:0] line_out
);

  logic ind_level;
  assign ind_level = any_act ? ind_hi : ~ind_hi;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic drdy_owns;
    logic ind_owns;
    assign drdy_owns   = drdy_en && (drdy_sel == SEL_W'(i));
    assign ind_owns    = ind_en && (ind_sel == SEL_W'(i));
    assign line_out[i] = drdy_owns ? drdy_lvl : (ind_owns ? ind_level : gpio_lvl[i]);
  end

endmodule

// File: rtl/dual_alarm_monitor.sv
`timescale 1ns/1ps
module dual_alarm_monitor
  import alarm_mon_pkg::*;
#(
  parameter int LANES = 8,
  parameter int HIST_DEPTH = 256,
  localparam int BUS_W = LANES * SMP_W,
  localparam int LAG_W = $clog2(HIST_DEPTH),
  localparam int N_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [BUS_W-1:0] raw_bus,
  input  logic [BUS_W-1:0] filt_bus,
  input  logic [SMP_W-1:0] status_word,
  input  logic [15:0]      ctrl_word,
  input  logic [SMP_W-1:0] thresh1,
  input  logic [SMP_W-1:0] thresh2,
  input  logic [LAG_W-1:0] window1,
  input  logic [LAG_W-1:0] window2,
  input  logic             flag_clr,
  input  logic             drdy_en,
  input  logic             drdy_sel,
  input  logic             drdy_lvl,
  input  logic [1:0]       gpio_lvl,
  output logic [N_CH-1:0]  alarm_active,
  output logic [N_CH-1:0]  alarm_flag,
  output logic [1:0]       line_out
);

  // Internal events brought out for the checker.
  logic [N_CH-1:0] src_chg;
  logic [N_CH-1:0] trip;
  logic [N_CH-1:0] hist_ready;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    chan_cfg_t        cfg;
    src_sel_t         src_q;
    logic [SMP_W-1:0] val;
    logic [SMP_W-1:0] old_val;
    logic [SMP_W-1:0] thr;
    logic [LAG_W-1:0] win;
    logic             valid;
    logic             act_q;
    logic             flag_q;

    assign cfg = cfg_of(ctrl_word, ch);
    assign thr = (ch == 0) ? thresh1 : thresh2;
    assign win = (ch == 0) ? window1 : window2;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= cfg.src;
    end
    assign src_chg[ch] = (cfg.src != src_q);

    alarm_src_mux #(.LANES(LANES)) u_mux (
      .raw_bus    (raw_bus),
      .filt_bus   (filt_bus),
      .status_word(status_word),
      .use_filt   (ctrl_word[3]),
      .sel        (cfg.src),
      .value      (val),
      .valid      (valid)
    );

    alarm_history #(.DEPTH(HIST_DEPTH)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (sample_stb),
      .flush  (src_chg[ch]),
      .din    (val),
      .lag    (win),
      .old_val(old_val),
      .ready  (hist_ready[ch])
    );

    alarm_eval u_eval (
      .cfg       (cfg),
      .value     (val),
      .valid     (valid),
      .old_val   (old_val),
      .hist_ready(hist_ready[ch]),
      .thr       (thr),
      .trip      (trip[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        if (sample_stb) act_q <= trip[ch];
        flag_q <= (flag_q && !flag_clr) || (sample_stb && trip[ch]);
      end
    end

    assign alarm_active[ch] = act_q;
    assign alarm_flag[ch]   = flag_q;
  end

  alarm_pin_route #(.LINES(2)) u_route (
    .any_act (|alarm_active),
    .ind_en  (ctrl_word[2]),
    .ind_hi  (ctrl_word[1]),
    .ind_sel (ctrl_word[0]),
    .drdy_en (drdy_en),
    .drdy_sel(drdy_sel),
    .drdy_lvl(drdy_lvl),
    .gpio_lvl(gpio_lvl),
    .line_out(line_out)
  );

endmodule

// File: rtl/alarm_monitor_chk.sv
`timescale 1ns/1ps
module alarm_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_stb,
  input logic [15:0] ctrl_word,
  input logic       flag_clr,
  input logic       drdy_en,
  input logic       drdy_sel,
  input logic       drdy_lvl,
  input logic [1:0] src_chg,
  input logic [1:0] alarm_active,
  input logic [1:0] alarm_flag,
  input logic [1:0] line_out
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(alarm_active));

  assert_flag_on_rise0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_active[0]) |-> alarm_flag[0]);

  assert_flag_on_rise1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_active[1]) |-> alarm_flag[1]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag[0] && !flag_clr) |=> alarm_flag[0]);

  assert_off_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && ctrl_word[11:8] == 4'd0) |=> !alarm_active[0]);

  assert_fresh_history_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && src_chg[1] && ctrl_word[7]) |=> !alarm_active[1]);

  assert_drdy_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_en |-> (line_out[drdy_sel] == drdy_lvl));

endmodule

bind dual_alarm_monitor alarm_monitor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .ctrl_word   (ctrl_word),
  .flag_clr    (flag_clr),
  .drdy_en     (drdy_en),
  .drdy_sel    (drdy_sel),
  .drdy_lvl    (drdy_lvl),
  .src_chg     (src_chg),
  .alarm_active(alarm_active),
  .alarm_flag  (alarm_flag),
  .line_out    (line_out)
);

// File: tb/dual_alarm_monitor_tb.sv
`timescale 1ns/1ps
module dual_alarm_monitor_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sample_stb;
  logic [127:0] raw_bus, filt_bus;
  logic [15:0]  status_word, ctrl_word, thresh1, thresh2;
  logic [7:0]   window1, window2;
  logic         flag_clr, drdy_en, drdy_sel, drdy_lvl;
  logic [1:0]   gpio_lvl;
  wire  [1:0]   alarm_active, alarm_flag, line_out;

  always #5 clk = ~clk;

  dual_alarm_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .raw_bus(raw_bus), .filt_bus(filt_bus), .status_word(status_word),
    .ctrl_word(ctrl_word), .thresh1(thresh1), .thresh2(thresh2),
    .window1(window1), .window2(window2), .flag_clr(flag_clr),
    .drdy_en(drdy_en), .drdy_sel(drdy_sel), .drdy_lvl(drdy_lvl),
    .gpio_lvl(gpio_lvl), .alarm_active(alarm_active),
    .alarm_flag(alarm_flag), .line_out(line_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  int hist [2][256];
  int hcnt [2];
  int hwp  [2];
  int m_src [2];
  bit m_act [2];
  bit m_flag [2];

  function automatic logic [15:0] mkc(int s1, int s2, bit d1, bit d2, bit p1, bit p2,
                                      bit f, bit ie, bit ih, bit il);
    return {4'(s2), 4'(s1), d2, d1, p2, p1, f, ie, ih, il};
  endfunction

  function automatic bit code_ok(int code);
    return (code >= 1) && (code <= 9);
  endfunction

  function automatic int src_value(int code, bit filt);
    logic [15:0] w;
    if (code == 9) return (status_word != 16'd0) ? 1 : 0;
    if (!code_ok(code)) return 0;
    w = filt ? filt_bus[(code-1)*16 +: 16] : raw_bus[(code-1)*16 +: 16];
    return int'($signed(w));
  endfunction

  task automatic model_edge();
    for (int ch = 0; ch < 2; ch++) begin
      int code = (ch == 1) ? int'(ctrl_word[15:12]) : int'(ctrl_word[11:8]);
      bit dyn  = ctrl_word[6 + ch];
      bit gt   = ctrl_word[4 + ch];
      int thr  = (ch == 1) ? int'($signed(thresh2)) : int'($signed(thresh1));
      int n    = (ch == 1) ? int'(window2) : int'(window1);
      if (n == 0) n = 1;
      if (code != m_src[ch]) begin
        hcnt[ch] = 0;
        m_src[ch] = code;
      end
      if (flag_clr) m_flag[ch] = 1'b0;
      if (sample_stb) begin
        int v = src_value(code, ctrl_word[3]);
        bit act = 1'b0;
        if (code_ok(code)) begin
          if (dyn) begin
            if (hcnt[ch] >= n) begin
              int d = v - hist[ch][(hwp[ch] - n) & 255];
              act = gt ? (d > thr) : (d < thr);
            end
          end else begin
            act = gt ? (v > thr) : (v < thr);
          end
        end
        m_act[ch] = act;
        if (act) m_flag[ch] = 1'b1;
        hist[ch][hwp[ch]] = v;
        hwp[ch] = (hwp[ch] + 1) & 255;
        if (hcnt[ch] < 256) hcnt[ch]++;
      end
    end
  endtask

  function automatic bit exp_line(int i);
    if (drdy_en && int'(drdy_sel) == i) return drdy_lvl;
    if (ctrl_word[2] && int'(ctrl_word[0]) == i)
      return (m_act[0] | m_act[1]) ? ctrl_word[1] : !ctrl_word[1];
    return gpio_lvl[i];
  endfunction

  task automatic check(string tag, string what, logic [1:0] got, logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(tag, "active", alarm_active, {m_act[1], m_act[0]});
    check(tag, "flag", alarm_flag, {m_flag[1], m_flag[0]});
    check(tag, "line", line_out, {exp_line(1), exp_line(0)});
  endtask

  task automatic set_lane(int lane, int rv, int fv);
    raw_bus[lane*16 +: 16]  = 16'(rv);
    filt_bus[lane*16 +: 16] = 16'(fv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin
      hcnt[c] = 0; hwp[c] = 0; m_src[c] = 0; m_act[c] = 0; m_flag[c] = 0;
    end
    rst_n = 0; sample_stb = 0; raw_bus = '0; filt_bus = '0; status_word = 0;
    ctrl_word = 0; thresh1 = 0; thresh2 = 0; window1 = 0; window2 = 0;
    flag_clr = 0; drdy_en = 0; drdy_sel = 0; drdy_lvl = 0; gpio_lvl = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8", "reset active", alarm_active, 2'b00);
    check("R8", "reset flag", alarm_flag, 2'b00);
    check("R10", "reset line", line_out, 2'b10);

    // R1: disabled code never fires
    sample_stb = 1;
    ctrl_word = mkc(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    thresh1 = 16'hFFFB; thresh2 = 16'hFFFB;
    cyc("R1");
    ctrl_word = mkc(12, 15, 0, 0, 1, 1, 0, 0, 0, 0);
    cyc("R1");
    // R1: status nonzero source
    ctrl_word = mkc(9, 0, 0, 0, 1, 0, 0, 0, 0, 0); thresh1 = 0; status_word = 16'h0005;
    cyc("R1");
    status_word = 0;
    cyc("R1");
    // R1: lane decode, lane 2 high, others low
    for (int l = 0; l < 8; l++) set_lane(l, -50, -50);
    set_lane(2, 50, 50);
    ctrl_word = mkc(3, 2, 0, 0, 1, 1, 0, 0, 0, 0); thresh1 = 10; thresh2 = 10;
    cyc("R1");
    // R2: raw versus filtered
    set_lane(3, 100, -100);
    ctrl_word = mkc(4, 4, 0, 0, 1, 0, 0, 0, 0, 0); thresh1 = 0; thresh2 = 0;
    cyc("R2");
    ctrl_word[3] = 1'b1;
    cyc("R2");
    // R3: greater-than, equality and signedness
    ctrl_word = mkc(1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    set_lane(0, 20, 20); thresh1 = 20; thresh2 = 19;
    cyc("R3");
    set_lane(0, 21, 21);
    cyc("R3");
    set_lane(0, -1, -1); thresh1 = 1; thresh2 = 16'hFFFE;
    cyc("R3");
    // R4: less-than
    ctrl_word = mkc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    set_lane(0, 19, 19); thresh1 = 20; thresh2 = 19;
    cyc("R4");
    set_lane(0, -32768, -32768); thresh1 = 16'h7FFF; thresh2 = 16'h8000;
    cyc("R4");
    // R5/R6: rate mode, window 3, extreme swing after a source change
    ctrl_word = mkc(2, 2, 1, 1, 1, 0, 0, 0, 0, 0);
    window1 = 3; window2 = 0; thresh1 = 16'h7FFF; thresh2 = 16'h8000;
    set_lane(1, -32768, 0);
    cyc("R6");
    set_lane(1, 0, 0);
    cyc("R6");
    cyc("R6");
    set_lane(1, 32767, 0);
    cyc("R5");
    set_lane(1, -32768, 0);
    cyc("R5");
    window1 = 0;
    set_lane(1, 100, 0);
    cyc("R5");
    // R7: no strobe, inputs move, results hold
    sample_stb = 0;
    set_lane(1, -30000, 0);
    cyc("R7");
    cyc("R7");
    // R8: sticky flag and clear
    flag_clr = 1;
    cyc("R8");
    flag_clr = 0;
    sample_stb = 1;
    ctrl_word = mkc(1, 0, 0, 0, 1, 0, 0, 0, 0, 0); set_lane(0, 5, 5); thresh1 = 0;
    cyc("R8");
    flag_clr = 1;
    cyc("R8");
    flag_clr = 0; set_lane(0, -5, -5);
    cyc("R8");
    // R9: indicator polarity and line choice
    gpio_lvl = 2'b11;
    ctrl_word = mkc(1, 0, 0, 0, 1, 0, 0, 1, 0, 1); set_lane(0, 5, 5);
    cyc("R9");
    ctrl_word = mkc(1, 0, 0, 0, 1, 0, 0, 1, 1, 0);
    cyc("R9");
    set_lane(0, -5, -5);
    cyc("R9");
    // R10: data-ready wins its line
    ctrl_word = mkc(1, 0, 0, 0, 1, 0, 0, 1, 1, 0); set_lane(0, 5, 5);
    drdy_en = 1; drdy_sel = 0; drdy_lvl = 0;
    cyc("R10");
    drdy_sel = 1; drdy_lvl = 0;
    cyc("R10");
    drdy_en = 0;
    // R6: full window of 255 samples on a ramp
    ctrl_word = mkc(5, 0, 1, 0, 1, 0, 0, 0, 0, 0); window1 = 255; thresh1 = 254;
    for (int i = 0; i < 257; i++) begin
      set_lane(4, i, i);
      cyc("R6");
    end
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 37 == 0) begin
        ctrl_word = 16'($urandom);
        ctrl_word[11:8]  = 4'($urandom_range(11));
        ctrl_word[15:12] = 4'($urandom_range(11));
        window1 = 8'($urandom_range(4));
        window2 = 8'($urandom_range(4));
        thresh1 = 16'(int'($urandom_range(8)) - 4);
        thresh2 = 16'(int'($urandom_range(8)) - 4);
      end
      for (int l = 0; l < 8; l++)
        set_lane(l, int'($urandom_range(12)) - 6, int'($urandom_range(12)) - 6);
      status_word = ($urandom_range(3) == 0) ? 16'h0010 : 16'h0000;
      sample_stb = ($urandom_range(9) < 7);
      flag_clr   = ($urandom_range(9) == 0);
      drdy_en    = 1'($urandom); drdy_sel = 1'($urandom); drdy_lvl = 1'($urandom);
      gpio_lvl   = 2'($urandom);
      cyc("R7");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule